// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block fetches outgoing frames for an Ethernet transmitter from a ring of descriptors held in system memory. A transmit demand, accepted only while the controller is enabled, starts a walk at the ring position reached by the previous walk. Each descriptor is eight bytes long and big-endian. It carries a flags half-word, a byte-count half-word and a 32-bit buffer pointer. The engine gathers the buffers of consecutive descriptors into one frame until it reaches a descriptor marked as the last. It sends the frame out one byte per cycle, with start and end markers.

After each descriptor has been consumed, the engine writes the descriptor's first word back with the ready flag cleared. It then signals a per-buffer or per-frame event and moves on, either to the next slot or back to the ring base. A walk stops at the first descriptor that is not ready, or after a fixed number of descriptors. Frames longer than a fixed cap are cut off and flagged. The memory side is a simple request/acknowledge word port. Collisions, padding and CRC are handled elsewhere.

Top module: `tx_desc_ring`

## Requirements
- R1: A pulse on `tx_demand` starts a walk only when `ctrl_en` is 1. With `ctrl_en` at 0 the pulse is ignored: `busy` stays 0 and no memory request is made.
- R2: A descriptor is read as two word reads, at the ring position and at the position plus 4. In a memory word, the byte at the lowest address sits in bits 7:0. Bytes 0–1 hold the flags and bytes 2–3 hold the length, both big-endian. Bytes 4–7 hold the big-endian buffer pointer. An outstanding request keeps its address until acknowledged.
- R3: A descriptor whose ready flag (flags bit 15) is 0 ends the walk. It is not written back, and the ring position stays on it.
- R4: Buffer bytes leave on `out_data` in address order, starting at any byte alignment. A frame spans descriptors until one with the last flag (flags bit 11). `out_sop` marks the first byte of the frame and `out_eop` marks its last byte.
- R5: Each consumed descriptor has its first word written back to its own address, identical except that the ready flag is cleared. This write happens before the next descriptor is read.
- R6: Each consumed descriptor without the last flag gives a one-cycle `ev_buf` pulse. Each consumed descriptor with the last flag gives a one-cycle `ev_frame` pulse.
- R7: After a descriptor with the wrap flag (flags bit 13), the next position is `ring_base`; otherwise it is the position plus 8. The position persists between walks. A `ring_set` pulse while idle loads `ring_base`.
- R8: A frame never exceeds MAX_FRAME bytes (2032 by default). Bytes of a buffer that do not fit are dropped, and `ev_babble` pulses at that descriptor's write-back.
- R9: A walk consumes at most MAX_DESC descriptors (1024 by default) and then stops at the following position.
- R10: A demand that arrives during a walk is remembered, and one further walk starts after the current one ends.
- R11: When a walk ends in the middle of a frame, the next walk continues the same frame without a new start marker.
- R12: A frame that collects no bytes produces no stream output but still raises `ev_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; gates demands |
| tx_demand | input | 1 | One-cycle transmit demand |
| ring_set | input | 1 | Load ring position from `ring_base` while idle |
| ring_base | input | AW | Ring start address, 8-byte aligned |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current request |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |
| ev_buf | output | 1 | Buffer consumed, frame continues |
| ev_frame | output | 1 | Frame closed |
| ev_babble | output | 1 | Frame truncated at the size cap |
| busy | output | 1 | Walk in progress |

## Verification
A wrong frame-size count shows up as a misplaced `out_eop` or a missing `ev_babble` at the end of the first frame it affects. A wrong ring position shows up on `mem_addr` at the very next descriptor read, and a wrong byte-lane select corrupts `out_data` within one word of the buffer start. A lost pending demand or a wrong descriptor count shows up as a missing or extra descriptor read once the walk finishes. A faulty write-back image is visible in the descriptor word in memory as soon as the write completes.

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
  parameter int AW        = 32,
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          tx_demand,
  input  logic          ring_set,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble,
  output logic          busy
);
  localparam int FW = $clog2(MAX_FRAME + 1);
  localparam int CW = $clog2(MAX_DESC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_DRD, S_DST, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] cur, ptr;
  logic          pend, trunc;
  logic [CW-1:0] dcnt;
  logic [15:0]   flg, len, remain;
  logic [FW-1:0] fsize;
  logic [31:0]   word;
  logic [7:0]    hold;
  logic          hold_v, hold_first;

  logic [16:0] room, take;
  logic [15:0] flg_wb;
  logic [7:0]  lane_byte;

  assign room      = 17'(MAX_FRAME) - 17'(fsize);
  assign take      = ({1'b0, len} > room) ? room : {1'b0, len};
  assign flg_wb    = flg & 16'h7fff;
  assign lane_byte = word[{ptr[1:0], 3'b000} +: 8];

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_DRD) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = {len[7:0], len[15:8], flg_wb[7:0], flg_wb[15:8]};

  always_comb begin
    case (st)
      S_RD1:   mem_addr = cur + AW'(4);
      S_DRD:   mem_addr = {ptr[AW-1:2], 2'b00};
      default: mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur        <= '0;
      ptr        <= '0;
      pend       <= 1'b0;
      trunc      <= 1'b0;
      dcnt       <= '0;
      flg        <= '0;
      len        <= '0;
      remain     <= '0;
      fsize      <= '0;
      word       <= '0;
      hold       <= '0;
      hold_v     <= 1'b0;
      hold_first <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      ev_buf     <= 1'b0;
      ev_frame   <= 1'b0;
      ev_babble  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
      if (st != S_IDLE && tx_demand && ctrl_en) pend <= 1'b1;

      case (st)
        S_IDLE: begin
          if (ring_set) cur <= ring_base;
          if (pend || (tx_demand && ctrl_en)) begin
            pend <= 1'b0;
            dcnt <= '0;
            st   <= S_RD0;
          end
        end

        S_RD0: if (mem_ack) begin
          flg <= {mem_rdata[7:0], mem_rdata[15:8]};
          len <= {mem_rdata[23:16], mem_rdata[31:24]};
          st  <= mem_rdata[7] ? S_RD1 : S_IDLE;
        end

        S_RD1: if (mem_ack) begin
          ptr    <= AW'({mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]});
          trunc  <= ({1'b0, len} > room);
          remain <= take[15:0];
          st     <= (take == 17'd0) ? S_WB : S_DRD;
        end

        S_DRD: if (mem_ack) begin
          word <= mem_rdata;
          st   <= S_DST;
        end

        S_DST: begin
          if (hold_v) begin
            out_valid <= 1'b1;
            out_data  <= hold;
            out_sop   <= hold_first;
          end
          hold       <= lane_byte;
          hold_v     <= 1'b1;
          hold_first <= (fsize == '0);
          ptr        <= ptr + AW'(1);
          remain     <= remain - 16'd1;
          fsize      <= fsize + FW'(1);
          if (remain == 16'd1)       st <= S_WB;
          else if (ptr[1:0] == 2'd3) st <= S_DRD;
        end

        S_WB: if (mem_ack) begin
          ev_babble <= trunc;
          if (flg[11]) begin
            ev_frame <= 1'b1;
            fsize    <= '0;
            if (hold_v) begin
              out_valid <= 1'b1;
              out_data  <= hold;
              out_sop   <= hold_first;
              out_eop   <= 1'b1;
              hold_v    <= 1'b0;
            end
          end else begin
            ev_buf <= 1'b1;
          end
          cur  <= flg[13] ? ring_base : cur + AW'(8);
          dcnt <= dcnt + CW'(1);
          st   <= (dcnt == CW'(MAX_DESC - 1)) ? S_IDLE : S_RD0;
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_ring_chk.sv
module tx_desc_ring_chk #(
  parameter int AW        = 32,
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_sop,
  input logic          out_eop,
  input logic          ev_buf,
  input logic          ev_frame,
  input logic          busy
);
  logic [15:0] fcnt;
  logic        in_frame;
  logic [31:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt     <= '0;
      in_frame <= 1'b0;
      wcnt     <= '0;
    end else begin
      if (out_valid) begin
        fcnt     <= out_sop ? 16'd1 : fcnt + 16'd1;
        in_frame <= !out_eop;
      end
      if (!busy) wcnt <= '0;
      else if (mem_req && mem_we && mem_ack) wcnt <= wcnt + 32'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_sop_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !in_frame);
  assert_body_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> in_frame);
  assert_wb_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[2:0] == 3'd0));
  assert_event_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_buf && ev_frame));
  assert_frame_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> (fcnt < 16'(MAX_FRAME)));
  assert_walk_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= 32'(MAX_DESC));
endmodule

bind tx_desc_ring tx_desc_ring_chk #(.AW(AW), .MAX_DESC(MAX_DESC), .MAX_FRAME(MAX_FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .ev_buf(ev_buf), .ev_frame(ev_frame), .busy(busy));

// File: tb/test_tx_desc_ring.sv
`timescale 1ns/1ps
module test_tx_desc_ring;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic ctrl_en = 0, tx_demand = 0, ring_set = 0;
  logic [AW-1:0] ring_base = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic out_valid, out_sop, out_eop, ev_buf, ev_frame, ev_babble, busy;
  logic [7:0] out_data;

  tx_desc_ring #(.AW(AW), .MAX_DESC(4), .MAX_FRAME(2032)) i_tx_desc_ring (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .tx_demand(tx_demand), .ring_set(ring_set),
    .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .ev_buf(ev_buf),
    .ev_frame(ev_frame), .ev_babble(ev_babble), .busy(busy));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] m [0:16383];
  logic [13:0] watch_addr = '0;
  int watch_reads = 0, req_cycles = 0, busy_rises = 0;
  int n_buf = 0, n_frame = 0, n_bab = 0, n_out = 0;
  logic [7:0] ob [0:4095];
  logic os [0:4095];
  logic oe [0:4095];
  logic prev_busy = 0;
  logic [7:0] exp_b [0:4095];
  int n_exp = 0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          m[mem_addr[13:0]]      <= mem_wdata[7:0];
          m[mem_addr[13:0] + 1]  <= mem_wdata[15:8];
          m[mem_addr[13:0] + 2]  <= mem_wdata[23:16];
          m[mem_addr[13:0] + 3]  <= mem_wdata[31:24];
        end else begin
          mem_rdata <= {m[mem_addr[13:0]+3], m[mem_addr[13:0]+2], m[mem_addr[13:0]+1], m[mem_addr[13:0]]};
          if (mem_addr[13:0] == watch_addr) watch_reads <= watch_reads + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) req_cycles++;
      if (busy && !prev_busy) busy_rises++;
      prev_busy = busy;
      if (ev_buf) n_buf++;
      if (ev_frame) n_frame++;
      if (ev_babble) n_bab++;
      if (out_valid && n_out < 4096) begin
        ob[n_out] = out_data; os[n_out] = out_sop; oe[n_out] = out_eop; n_out++;
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired: cycles act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr;
    n_buf = 0; n_frame = 0; n_bab = 0; n_out = 0; n_exp = 0;
    watch_reads = 0; req_cycles = 0; busy_rises = 0;
  endtask

  task automatic set_desc(input int a, input int flags, input int len, input int ptr);
    m[a]   = flags[15:8]; m[a+1] = flags[7:0];
    m[a+2] = len[15:8];   m[a+3] = len[7:0];
    m[a+4] = ptr[31:24];  m[a+5] = ptr[23:16];
    m[a+6] = ptr[15:8];   m[a+7] = ptr[7:0];
  endtask

  task automatic expect_buf(input int ptr, input int n);
    for (int i = 0; i < n; i++) begin exp_b[n_exp] = m[ptr+i]; n_exp++; end
  endtask

  task automatic set_ring(input int base);
    @(negedge clk); ring_base = base; ring_set = 1;
    @(negedge clk); ring_set = 0;
  endtask

  task automatic demand;
    @(negedge clk); tx_demand = 1;
    @(negedge clk); tx_demand = 0;
  endtask

  task automatic wait_idle;
    int q;
    q = 0;
    repeat (2) @(negedge clk);
    while (q < 6) begin
      @(negedge clk);
      if (!busy && !mem_req) q++; else q = 0;
    end
  endtask

  task automatic chk_stream(input string tag);
    int bad;
    bad = 0;
    chk({tag, " byte count"}, n_out, n_exp);
    for (int i = 0; i < n_out && i < n_exp; i++) if (ob[i] != exp_b[i]) bad++;
    chk({tag, " byte mismatches"}, bad, 0);
  endtask

  task automatic chk_markers(input string tag);
    int sops, eops;
    sops = 0; eops = 0;
    for (int i = 0; i < n_out; i++) begin sops += os[i]; eops += oe[i]; end
    chk({tag, " sop on first"}, os[0], 1);
    chk({tag, " eop on last"}, oe[n_out-1], 1);
    chk({tag, " sop total"}, sops, 1);
    chk({tag, " eop total"}, eops, 1);
  endtask

  task automatic t_reset;
    chk("reset busy", busy, 0);
    chk("reset mem_req", mem_req, 0);
    chk("reset out_valid", out_valid, 0);
    chk("reset events", {ev_buf, ev_frame, ev_babble}, 0);
  endtask

  task automatic t_disabled;
    clr();
    ctrl_en = 0;
    demand();
    repeat (10) @(negedge clk);
    chk("R1 disabled demand: no requests", req_cycles, 0);
    chk("R1 disabled demand: busy never rose", busy_rises, 0);
    ctrl_en = 1;
  endtask

  task automatic t_single;
    clr();
    set_ring(32'h100);
    set_desc(32'h100, 16'h8800, 5, 32'h1003);
    expect_buf(32'h1003, 5);
    demand(); wait_idle();
    chk_stream("R4 single unaligned");
    chk_markers("R4 single");
    chk("R6 single ev_frame", n_frame, 1);
    chk("R6 single ev_buf", n_buf, 0);
    chk("R5 ready cleared flags hi", m[32'h100], 8'h08);
    chk("R5 flags lo kept", m[32'h101], 8'h00);
    chk("R5 length kept", {m[32'h102], m[32'h103]}, 5);
    chk("R2 pointer untouched", {m[32'h104], m[32'h105], m[32'h106], m[32'h107]}, 32'h1003);
  endtask

  task automatic t_chain;
    clr();
    watch_addr = 14'h100;
    set_desc(32'h108, 16'h8000, 3, 32'h1100);
    set_desc(32'h110, 16'hA800, 4, 32'h1202);
    expect_buf(32'h1100, 3);
    expect_buf(32'h1202, 4);
    demand(); wait_idle();
    chk_stream("R4 chained frame");
    chk_markers("R4 chained");
    chk("R6 chain ev_buf", n_buf, 1);
    chk("R6 chain ev_frame", n_frame, 1);
    chk("R7 position advanced then wrapped to base", watch_reads, 1);
  endtask

  task automatic t_stop;
    logic [7:0] snap [0:7];
    clr();
    for (int i = 0; i < 8; i++) snap[i] = m[32'h100 + i];
    demand(); wait_idle();
    chk("R3 not-ready: no output", n_out, 0);
    chk("R3 not-ready: no events", n_buf + n_frame, 0);
    begin
      int d;
      d = 0;
      for (int i = 0; i < 8; i++) if (m[32'h100 + i] != snap[i]) d++;
      chk("R3 not-ready: descriptor unchanged", d, 0);
    end
    chk("R3 not-ready: read at same position", watch_reads, 1);
  endtask

  task automatic t_pending;
    clr();
    set_ring(32'h300);
    watch_addr = 14'h308;
    set_desc(32'h300, 16'h8800, 2, 32'h1400);
    expect_buf(32'h1400, 2);
    @(negedge clk); tx_demand = 1;
    @(negedge clk); tx_demand = 0;
    @(negedge clk); tx_demand = 1;
    @(negedge clk); tx_demand = 0;
    wait_idle();
    chk("R10 second walk ran", busy_rises, 2);
    chk("R10 stop slot read twice", watch_reads, 2);
    chk_stream("R10 frame");
  endtask

  task automatic t_maxdesc;
    clr();
    set_ring(32'h400);
    for (int i = 0; i < 5; i++) begin
      set_desc(32'h400 + 8*i, 16'h8000, 1, 32'h1500 + i);
    end
    set_desc(32'h428, 16'hA800, 1, 32'h1505);
    expect_buf(32'h1500, 6);
    demand(); wait_idle();
    chk("R9 walk stopped after 4 descriptors", n_buf, 4);
    chk("R9 fifth descriptor still ready", m[32'h420], 8'h80);
    chk("R9 fourth descriptor cleared", m[32'h418], 8'h00);
    chk("R11 partial frame bytes out", n_out, 3);
    demand(); wait_idle();
    chk_stream("R11 frame resumed");
    chk_markers("R11 resumed");
    chk("R11 ev_buf total", n_buf, 5);
    chk("R11 ev_frame total", n_frame, 1);
  endtask

  task automatic t_babble;
    clr();
    set_ring(32'h600);
    set_desc(32'h600, 16'h8000, 2000, 32'h2000);
    set_desc(32'h608, 16'h8800, 100, 32'h2900);
    expect_buf(32'h2000, 2000);
    expect_buf(32'h2900, 32);
    demand(); wait_idle();
    chk_stream("R8 capped frame");
    chk_markers("R8 capped");
    chk("R8 ev_babble once", n_bab, 1);
    chk("R8 ev_frame", n_frame, 1);
  endtask

  task automatic t_empty;
    clr();
    set_ring(32'h700);
    set_desc(32'h700, 16'h8800, 0, 32'h1600);
    demand(); wait_idle();
    chk("R12 empty frame: no output", n_out, 0);
    chk("R12 empty frame: ev_frame", n_frame, 1);
    chk("R12 empty frame: ev_buf", n_buf, 0);
    chk("R12 empty frame: written back", m[32'h700], 8'h08);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) m[i] = (i >= 32'h1000) ? 8'((i * 13 + 5) & 255) : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    ctrl_en = 1;
    t_single();
    t_chain();
    t_stop();
    t_pending();
    t_maxdesc();
    t_babble();
    t_empty();
    summary();
    $finish;
  end
endmodule